// File: doc/BRIEF.md
# SDRAM Command Decoder with Bank State Tracking

This block sits on the device side of a single-data-rate SDRAM interface. On every rising clock edge it samples chip select, the three strobes (row, column, write enable), clock enable, a two-bit bank address and a 13-bit address bus. It turns that sample into one command code and keeps a record of which of four banks holds an open row. Any command that the current bank state forbids is flagged as illegal.

The block latches the row address on a legal activate, the column address on a legal read or write, and the mode value on a legal mode register write. It also tracks reads and writes with auto-precharge: a counter per bank closes the bank a fixed number of cycles after the access, and until that happens the bank rejects further commands. Every result is registered. It appears on the outputs one cycle after the edge that sampled the command.

Top module: `sdr_cmd_tracker`

## Requirements
- R1: While `rst_n` is low, all outputs read zero: command code 0, all banks idle, flags low, latched addresses and mode value zero.
- R2: With `cke` low the cycle decodes as NOP (code 0) and has no effect. With `cke` high and `cs_n` high it decodes as deselect (code 1) and has no effect, whatever the other pins hold.
- R3: With `cke` high and `cs_n` low, {ras_n,cas_n,we_n} decodes as follows, and the code appears on `cmd_code` after the sampling edge: 111 NOP=0, 011 ACT=2, 101 READ=3 (READA=4 if A10 high), 100 WRITE=5 (WRITEA=6 if A10 high), 010 PRE=7 (PREA=8 if A10 high), 110 TBST=9, 001 REFA=10, 000 MRS=11.
- R4: ACT to an idle bank sets bit `ba` of `bank_active` (bit i is bank i, 1 = row open) and latches A0–A12 into `row_addr`. ACT to an active bank is illegal.
- R5: READ/WRITE and their auto-precharge forms are legal only to an active bank with no auto-precharge pending. A legal access latches {A11, A9..A0} into `col_addr`, and the auto forms raise `auto_pre` for one cycle. The same commands sent to an idle bank are illegal.
- R6: PRE clears the addressed bank's bit. PRE to an idle bank is legal and changes nothing. PREA clears every bank and ignores `ba`.
- R7: TBST is illegal when the addressed bank is idle and legal when it is active. It changes no bank state.
- R8: REFA and MRS are illegal unless every bank is idle. MRS is also illegal unless `ba` is 0 and A7–A12 are all zero. A legal MRS latches A0–A6 into `mode_value`.
- R9: After a legal READA/WRITEA issued at clock edge n, the bank's bit clears at edge n+BURST_LEN. Until then, ACT, READ, WRITE and single-bank PRE to that bank are illegal.
- R10: An illegal command raises `illegal` for that result cycle only. It opens or closes no bank and latches no address or mode value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | Clock enable; low forces NOP |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank address |
| addr | input | 13 | Address bus A0–A12 |
| cmd_code | output | 4 | Decoded command code |
| illegal | output | 1 | Command illegal for current state |
| auto_pre | output | 1 | Legal access with auto-precharge |
| bank_active | output | 4 | Per-bank open-row state |
| row_addr | output | 13 | Last legally activated row |
| col_addr | output | 11 | Last legally accessed column |
| mode_value | output | 7 | Last legally written mode value |

## Verification
The command code, both flags, the latched addresses and the bank vector all depend on one sampling edge, so each is due exactly one edge after its command. The driver task sets each command at a falling edge and queues the expected result. The monitor compares it a nanosecond after the next rising edge. The auto-precharge close is due BURST_LEN edges after the access, so the bench issues NOPs in between and places the expected idle bit on the exact item of the queue where that close is due. One blocked write inside that window checks the pending-bank rule.

// File: rtl/sdr_cmd_tracker.sv
module sdr_cmd_tracker #(
  parameter int BANKS     = 4,
  parameter int BURST_LEN = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cke,
  input  logic                     cs_n,
  input  logic                     ras_n,
  input  logic                     cas_n,
  input  logic                     we_n,
  input  logic [$clog2(BANKS)-1:0] ba,
  input  logic [12:0]              addr,
  output logic [3:0]               cmd_code,
  output logic                     illegal,
  output logic                     auto_pre,
  output logic [BANKS-1:0]         bank_active,
  output logic [12:0]              row_addr,
  output logic [10:0]              col_addr,
  output logic [6:0]               mode_value
);
  localparam int CNT_W = $clog2(BURST_LEN + 1);
  localparam logic [3:0] C_NOP = 4'd0, C_DESEL = 4'd1, C_ACT = 4'd2, C_RD = 4'd3,
                         C_RDA = 4'd4, C_WR = 4'd5, C_WRA = 4'd6, C_PRE = 4'd7,
                         C_PREA = 4'd8, C_TBST = 4'd9, C_REFA = 4'd10, C_MRS = 4'd11;

  logic [3:0]       code;
  logic             bad;
  logic [BANKS-1:0] busy;

  wire a10     = addr[10];
  wire tgt_act = bank_active[ba];
  wire tgt_bsy = busy[ba];
  wire any_act = |bank_active;
  wire is_acc  = (code == C_RD) || (code == C_RDA) || (code == C_WR) || (code == C_WRA);
  wire is_auto = (code == C_RDA) || (code == C_WRA);

  always_comb begin
    if (!cke)       code = C_NOP;
    else if (cs_n)  code = C_DESEL;
    else begin
      case ({ras_n, cas_n, we_n})
        3'b111:  code = C_NOP;
        3'b011:  code = C_ACT;
        3'b101:  code = a10 ? C_RDA : C_RD;
        3'b100:  code = a10 ? C_WRA : C_WR;
        3'b010:  code = a10 ? C_PREA : C_PRE;
        3'b110:  code = C_TBST;
        3'b001:  code = C_REFA;
        default: code = C_MRS;
      endcase
    end
  end

  always_comb begin
    case (code)
      C_ACT:   bad = tgt_act;
      C_RD, C_RDA, C_WR, C_WRA: bad = !tgt_act || tgt_bsy;
      C_PRE:   bad = tgt_bsy;
      C_TBST:  bad = !tgt_act;
      C_REFA:  bad = any_act;
      C_MRS:   bad = any_act || (ba != '0) || (addr[12:7] != '0);
      default: bad = 1'b0;
    endcase
  end

  for (genvar i = 0; i < BANKS; i++) begin : g_bank
    logic [CNT_W-1:0] cnt;
    wire hit = (ba == i[$clog2(BANKS)-1:0]);
    assign busy[i] = (cnt != '0);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        bank_active[i] <= 1'b0;
        cnt            <= '0;
      end else begin
        if (cnt != '0) begin
          cnt <= cnt - 1'b1;
          if (cnt == 1) bank_active[i] <= 1'b0;
        end
        if (!bad) begin
          if (code == C_PREA) begin
            bank_active[i] <= 1'b0;
            cnt            <= '0;
          end else if (hit && code == C_PRE) begin
            bank_active[i] <= 1'b0;
          end else if (hit && code == C_ACT) begin
            bank_active[i] <= 1'b1;
          end else if (hit && is_auto) begin
            cnt <= CNT_W'(BURST_LEN);
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_code   <= C_NOP;
      illegal    <= 1'b0;
      auto_pre   <= 1'b0;
      row_addr   <= '0;
      col_addr   <= '0;
      mode_value <= '0;
    end else begin
      cmd_code <= code;
      illegal  <= bad;
      auto_pre <= !bad && is_auto;
      if (!bad && code == C_ACT) row_addr   <= addr;
      if (!bad && is_acc)        col_addr   <= {addr[11], addr[9:0]};
      if (!bad && code == C_MRS) mode_value <= addr[6:0];
    end
  end
endmodule

// File: rtl/sdr_cmd_tracker_sva.sv
module sdr_cmd_tracker_sva #(
  parameter int BANKS = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cke,
  input logic             cs_n,
  input logic [3:0]       cmd_code,
  input logic             illegal,
  input logic             auto_pre,
  input logic [BANKS-1:0] bank_active
);
  logic past_ok;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;

  a_r2_deselect: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
    ($past(cke) && $past(cs_n)) |-> (cmd_code == 4'd1 && !illegal));

  a_r8_refresh_all_idle: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
    (cmd_code == 4'd10 && !illegal) |-> ($past(bank_active) == '0));

  a_r4_act_opens_one: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
    (cmd_code == 4'd2 && !illegal) |-> $onehot(bank_active & ~$past(bank_active)));

  a_r6_prea_closes_all: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
    (cmd_code == 4'd8) |-> (bank_active == '0));

  a_r10_no_open_on_illegal: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
    illegal |-> ((bank_active & ~$past(bank_active)) == '0 && !auto_pre));
endmodule

bind sdr_cmd_tracker sdr_cmd_tracker_sva #(.BANKS(BANKS)) u_sva (
  .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .cmd_code(cmd_code),
  .illegal(illegal), .auto_pre(auto_pre), .bank_active(bank_active)
);

// File: tb/sdr_cmd_tracker_bench.sv
module sdr_cmd_tracker_bench;
  logic clk = 0, rst_n = 0;
  logic cke = 1, cs_n = 1, ras_n = 1, cas_n = 1, we_n = 1;
  logic [1:0] ba = 0;
  logic [12:0] addr = 0;
  logic [3:0] cmd_code, bank_active;
  logic illegal, auto_pre;
  logic [12:0] row_addr;
  logic [10:0] col_addr;
  logic [6:0] mode_value;

  sdr_cmd_tracker #(.BANKS(4), .BURST_LEN(4)) u_sdr_cmd_tracker (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .ba(ba), .addr(addr), .cmd_code(cmd_code), .illegal(illegal),
    .auto_pre(auto_pre), .bank_active(bank_active), .row_addr(row_addr),
    .col_addr(col_addr), .mode_value(mode_value));

  always #2 clk = ~clk;

  typedef struct {
    logic [3:0] c; logic il; logic ap; logic [3:0] b;
    logic [12:0] r; logic [10:0] k; logic [6:0] m; string tag;
  } item_t;
  item_t q[$];
  int checks = 0, fails = 0;
  logic [12:0] e_row = 0;
  logic [10:0] e_col = 0;
  logic [6:0]  e_mode = 0;

  task automatic cmd(input logic [2:0] rcw, input logic c_s, input logic c_ke,
                     input logic [1:0] b, input logic [12:0] a, input logic [3:0] ec,
                     input logic ei, input logic eap, input logic [3:0] eb, input string tag);
    item_t it;
    @(negedge clk);
    {ras_n, cas_n, we_n} = rcw; cs_n = c_s; cke = c_ke; ba = b; addr = a;
    it.c = ec; it.il = ei; it.ap = eap; it.b = eb;
    it.r = e_row; it.k = e_col; it.m = e_mode; it.tag = tag;
    q.push_back(it);
  endtask

  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      item_t e;
      e = q.pop_front();
      checks++;
      if (cmd_code !== e.c || illegal !== e.il || auto_pre !== e.ap || bank_active !== e.b ||
          row_addr !== e.r || col_addr !== e.k || mode_value !== e.m) begin
        fails++;
        $display("FAIL %s: got cmd=%0d ill=%b ap=%b banks=%b row=%h col=%h mode=%h exp cmd=%0d ill=%b ap=%b banks=%b row=%h col=%h mode=%h",
          e.tag, cmd_code, illegal, auto_pre, bank_active, row_addr, col_addr, mode_value,
          e.c, e.il, e.ap, e.b, e.r, e.k, e.m);
      end
    end
  end

  initial begin
    #800000;
    fails++; checks++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (cmd_code !== 0 || illegal !== 0 || auto_pre !== 0 || bank_active !== 0 ||
        row_addr !== 0 || col_addr !== 0 || mode_value !== 0) begin
      fails++;
      $display("FAIL R1 reset: got cmd=%0d banks=%b exp all zero", cmd_code, bank_active);
    end
    rst_n = 1;
    @(negedge clk);
    cmd(3'b000, 1, 1, 0, 13'h0000, 1, 0, 0, 4'b0000, "R2 deselect");
    cmd(3'b001, 0, 1, 0, 13'h0000, 10, 0, 0, 4'b0000, "R8 refresh all idle");
    e_mode = 7'h23;
    cmd(3'b000, 0, 1, 0, 13'h0023, 11, 0, 0, 4'b0000, "R8 mode write");
    cmd(3'b000, 0, 1, 0, 13'h0155, 11, 1, 0, 4'b0000, "R8 mode with A8 high");
    cmd(3'b101, 0, 1, 1, 13'h0001, 3, 1, 0, 4'b0000, "R5 read idle bank");
    cmd(3'b110, 0, 1, 1, 13'h0000, 9, 1, 0, 4'b0000, "R7 tbst idle bank");
    cmd(3'b010, 0, 1, 2, 13'h0000, 7, 0, 0, 4'b0000, "R6 pre idle bank");
    e_row = 13'h1ABC;
    cmd(3'b011, 0, 1, 1, 13'h1ABC, 2, 0, 0, 4'b0010, "R4 act bank1");
    cmd(3'b011, 0, 1, 1, 13'h0555, 2, 1, 0, 4'b0010, "R10 act active bank");
    e_row = 13'h0F0F;
    cmd(3'b011, 0, 1, 3, 13'h0F0F, 2, 0, 0, 4'b1010, "R4 act bank3");
    cmd(3'b001, 0, 1, 0, 13'h0000, 10, 1, 0, 4'b1010, "R8 refresh busy");
    cmd(3'b110, 0, 1, 1, 13'h0000, 9, 0, 0, 4'b1010, "R7 tbst active");
    e_col = 11'h4A5;
    cmd(3'b101, 0, 1, 1, 13'h08A5, 3, 0, 0, 4'b1010, "R5 read column");
    e_col = 11'h033;
    cmd(3'b100, 0, 1, 3, 13'h0433, 6, 0, 1, 4'b1010, "R5 writea");
    cmd(3'b111, 0, 1, 0, 13'h0000, 0, 0, 0, 4'b1010, "R9 pending 1");
    cmd(3'b100, 0, 1, 3, 13'h0011, 5, 1, 0, 4'b1010, "R9 write while pending");
    cmd(3'b111, 0, 1, 0, 13'h0000, 0, 0, 0, 4'b1010, "R9 pending 3");
    cmd(3'b111, 0, 1, 0, 13'h0000, 0, 0, 0, 4'b0010, "R9 auto close");
    e_row = 13'h0123;
    cmd(3'b011, 0, 1, 3, 13'h0123, 2, 0, 0, 4'b1010, "R4 reopen bank3");
    cmd(3'b010, 0, 1, 3, 13'h0000, 7, 0, 0, 4'b0010, "R6 pre bank3");
    cmd(3'b011, 0, 0, 0, 13'h1FFF, 0, 0, 0, 4'b0010, "R2 cke low");
    e_row = 13'h1FFF;
    cmd(3'b011, 0, 1, 0, 13'h1FFF, 2, 0, 0, 4'b0011, "R3 act bank0");
    cmd(3'b010, 0, 1, 2, 13'h0400, 8, 0, 0, 4'b0000, "R6 prea");
    cmd(3'b000, 0, 1, 1, 13'h0000, 11, 1, 0, 4'b0000, "R8 mode bad bank");
    cmd(3'b101, 0, 1, 0, 13'h0400, 4, 1, 0, 4'b0000, "R3 reada idle");
    cmd(3'b111, 1, 1, 0, 13'h0000, 1, 0, 0, 4'b0000, "R2 final deselect");
    while (q.size() > 0) @(negedge clk);
    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule